// File: doc/BRIEF.md
# I2C Slave with General Call Recognition

This block lets a host sit on a two-wire I2C bus as a slave. It samples the serial clock and data lines into the system clock domain and finds bus START and STOP conditions. It then collects the first byte after each START. That byte carries seven address bits, MSB first, followed by a direction bit. The byte is compared against a host-programmed 7-bit own address and, if enabled, against the all-zero general call byte. On a hit the block acknowledges the byte, records whether the hit was a general call and which direction was requested, and raises an interrupt.

A direction bit of 0 makes the block a slave receiver: each further byte is shifted in, acknowledged while the host allows it, and presented on `rx_data`. A direction bit of 1 makes it a slave transmitter: the byte on `tx_data` is sent MSB first and the master's acknowledge is read back. After every byte the block acknowledges or accepts, it holds SCL low until the host clears the interrupt. The `irq`/`irq_clr` pair is therefore the only flow control: the master is paused for as long as the host needs. Both bus outputs are open-drain enables, where a 1 pulls the line low.

Top module: `i2c_gc_slave`

## Requirements
- R1: After reset, scl_oe, sda_oe and irq are 0 and rx_data is 0.
- R2: An address byte whose upper seven bits equal own_addr is acknowledged (SDA pulled low during the ninth clock) when ack_en is 1, and irq rises with is_gc 0; with ack_en 0 it is not acknowledged.
- R3: The address byte 8'h00 is acknowledged, with irq and is_gc set, only when gc_en is 1; with gc_en 0 it gets no acknowledge and no irq.
- R4: Any other address byte gets no acknowledge and no irq, and the block drives neither line until the next START.
- R5: After each acknowledged byte, SCL is held low from the falling edge that ends the acknowledge clock until irq_clr is pulsed; irq is 0 in the cycle after the pulse and SCL is released.
- R6: With direction bit 0, each data byte, MSB first, is acknowledged while ack_en is 1 and appears on rx_data by the time irq rises.
- R7: If ack_en is 0 when a received data byte completes, the byte is not acknowledged, rx_data keeps its old value, irq stays 0, and the block stays silent until the next START.
- R8: With direction bit 1, is_tx is 1. The value of tx_data at the irq_clr pulse is sent MSB first, and later changes to tx_data do not alter that byte.
- R9: If the master does not acknowledge a transmitted byte, the block releases SDA, raises no irq and holds no clock, and further clocks read as all ones until the next START.
- R10: A START seen in the middle of a byte, or after an unmatched address, restarts address reception.
- R11: A STOP returns the block to idle; bytes clocked without a new START get no acknowledge and no irq.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or data 0) |
| own_addr | input | 7 | Programmed slave address |
| gc_en | input | 1 | Enables response to the general call byte |
| ack_en | input | 1 | Allows acknowledging address and received data |
| tx_data | input | 8 | Byte to send, sampled at the irq_clr pulse in transmit mode |
| irq_clr | input | 1 | One-cycle strobe that clears irq and ends the clock hold |
| irq | output | 1 | Interrupt: address matched or byte finished |
| rx_data | output | 8 | Last received and acknowledged data byte |
| is_gc | output | 1 | The last matched address was the general call |
| is_tx | output | 1 | The last matched address asked for transmit mode |

## Verification
The address comparator is swept over all 128 seven-bit addresses with a write direction. This separates exact own-address hits from near misses, and the general call from the own address; general call and ack_en are then toggled to isolate their gating. Receive mode is driven with a series of arithmetically generated byte values, which exposes bit-order and shift-count faults. Transmit mode returns a different generated series while tx_data is disturbed mid-byte, to show the byte is latched when the hold ends. Repeated STARTs mid-byte and after a miss, data and master NACK paths, and clocking after STOP each check that the block returns to the right listening state.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  // Protocol sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,   // waiting for START
    ST_RX,     // shifting a byte in (address or data)
    ST_ACK,    // pulling SDA low for the acknowledge clock
    ST_HOLD,   // stretching SCL until the host clears irq
    ST_SETUP,  // first transmit bit placed, SCL still held
    ST_TX,     // shifting a byte out
    ST_TACK,   // reading the master's acknowledge
    ST_DONE    // silent until the next START
  } i2cs_state_e;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 1) begin : g_single
      logic stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= RST_VAL;
        else        stage_q <= d;
      end
      assign q = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/i2cs_busmon.sv
module i2cs_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;

endmodule

// File: rtl/i2cs_shifter.sv
module i2cs_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        q <= '0;
    else if (load)     q <= load_val;
    else if (shift_en) q <= {q[W-2:0], bit_in};
  end

  // R8: a transmit load never coincides with a shift
  p_load_shift_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift_en));

endmodule

// File: rtl/i2c_gc_slave.sv
module i2c_gc_slave #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic [DATA_W-2:0] own_addr,
  input  logic              gc_en,
  input  logic              ack_en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              irq_clr,
  output logic              irq,
  output logic [DATA_W-1:0] rx_data,
  output logic              is_gc,
  output logic              is_tx
);
  import i2cs_pkg::*;

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  i2cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst_n(rst_n), .d(scl_i), .q(scl_s));
  i2cs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_i), .q(sda_s));

  i2cs_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  i2cs_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic              addr_ph, dir_r, gc_r, irq_r, mack_r;
  logic [DATA_W-1:0] rx_r;

  logic              sh_load, sh_shift, sh_in;
  logic [DATA_W-1:0] sh_q;

  i2cs_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .load_val(tx_data),
    .shift_en(sh_shift), .bit_in(sh_in), .q(sh_q));

  // address decode on the completed first byte
  logic own_hit, gc_hit, addr_ok;
  assign own_hit = (sh_q[DATA_W-1:1] == own_addr);
  assign gc_hit  = gc_en && (sh_q == '0);
  assign addr_ok = ack_en && (own_hit || gc_hit);

  assign sh_load  = (state == ST_HOLD) && irq_clr && dir_r;
  assign sh_shift = ((state == ST_RX) && scl_rise && (cnt != CNT_FULL)) ||
                    ((state == ST_TX) && scl_fall && (cnt != CNT_LAST));
  assign sh_in    = (state == ST_RX) ? sda_s : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      addr_ph <= 1'b0;
      dir_r   <= 1'b0;
      gc_r    <= 1'b0;
      irq_r   <= 1'b0;
      mack_r  <= 1'b0;
      rx_r    <= '0;
    end else begin
      if (irq_clr) irq_r <= 1'b0;
      if (stop_det) begin
        state <= ST_IDLE;
      end else if (start_det) begin
        state   <= ST_RX;
        cnt     <= '0;
        addr_ph <= 1'b1;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise && (cnt != CNT_FULL)) begin
              cnt <= cnt + CNT_W'(1);
            end else if (scl_fall && (cnt == CNT_FULL)) begin
              if (addr_ph) begin
                if (addr_ok) begin
                  state <= ST_ACK;
                  dir_r <= sh_q[0];
                  gc_r  <= gc_hit;
                end else begin
                  state <= ST_DONE;
                end
              end else if (ack_en) begin
                state <= ST_ACK;
                rx_r  <= sh_q;
              end else begin
                state <= ST_DONE;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state   <= ST_HOLD;
              irq_r   <= 1'b1;
              addr_ph <= 1'b0;
              cnt     <= '0;
            end
          end
          ST_HOLD: begin
            if (irq_clr) state <= dir_r ? ST_SETUP : ST_RX;
          end
          ST_SETUP: begin
            state <= ST_TX;
            cnt   <= '0;
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == CNT_LAST) begin
                state <= ST_TACK;
                cnt   <= '0;
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
          end
          ST_TACK: begin
            if (scl_rise) begin
              mack_r <= ~sda_s;
            end else if (scl_fall) begin
              if (mack_r) begin
                state <= ST_HOLD;
                irq_r <= 1'b1;
              end else begin
                state <= ST_DONE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign scl_oe  = (state == ST_HOLD) || (state == ST_SETUP);
  assign sda_oe  = (state == ST_ACK) ||
                   (((state == ST_SETUP) || (state == ST_TX)) && !sh_q[DATA_W-1]);
  assign irq     = irq_r;
  assign rx_data = rx_r;
  assign is_gc   = gc_r;
  assign is_tx   = dir_r;

  // R5: the clock is only stretched while the interrupt is pending
  p_hold_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |-> irq_r);

  // R5: a clear strobe during the hold ends it on the next cycle
  p_clr_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && state == ST_HOLD) |=> (!irq_r && state != ST_HOLD));

  // R3: a general call match needs the enable
  p_gc_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gc_r) |-> $past(gc_en));

  // R8: SDA drive only changes while the sampled clock was low
  p_sda_move_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !$past(scl_s));

  // R10: a START always restarts address reception
  p_start_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state == ST_RX && cnt == '0 && addr_ph));

  // R11: a STOP releases both lines
  p_stop_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state == ST_IDLE && !sda_oe && !scl_oe));

  // R7: a silent slave raises no interrupt
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> !$rose(irq_r));

endmodule

// File: tb/i2c_gc_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_gc_slave_tb_top;

  localparam int H = 10;
  localparam logic [6:0] OWN_A = 7'h2C;
  localparam logic [6:0] OWN_B = 7'h51;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic m_scl_low = 1'b0, m_sda_low = 1'b0;
  logic scl_oe, sda_oe, scl_line, sda_line;
  logic [6:0] own_addr = OWN_A;
  logic gc_en = 1'b1, ack_en = 1'b1, irq_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic irq, is_gc, is_tx;
  logic [7:0] rx_data;

  assign scl_line = !(m_scl_low || scl_oe);
  assign sda_line = !(m_sda_low || sda_oe);

  i2c_gc_slave dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(own_addr), .gc_en(gc_en),
    .ack_en(ack_en), .tx_data(tx_data), .irq_clr(irq_clr), .irq(irq),
    .rx_data(rx_data), .is_gc(is_gc), .is_tx(is_tx));

  int checks = 0, failures = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_high();
    while (!scl_line) @(negedge clk);
  endtask

  task automatic m_clk(input logic drv, output logic rd);
    m_sda_low = !drv;
    wait_cyc(H);
    m_scl_low = 1'b0;
    wait_scl_high();
    wait_cyc(H/2);
    rd = sda_line;
    wait_cyc(H/2);
    m_scl_low = 1'b1;
    wait_cyc(H);
  endtask

  task automatic m_start();
    m_sda_low = 1'b0;
    wait_cyc(H);
    m_scl_low = 1'b0;
    wait_scl_high();
    wait_cyc(H);
    m_sda_low = 1'b1;
    wait_cyc(H);
    m_scl_low = 1'b1;
    wait_cyc(H);
  endtask

  task automatic m_stop();
    m_sda_low = 1'b1;
    wait_cyc(H);
    m_scl_low = 1'b0;
    wait_scl_high();
    wait_cyc(H);
    m_sda_low = 1'b0;
    wait_cyc(H);
  endtask

  task automatic m_write(input logic [7:0] b, output logic ack);
    logic rd;
    for (int i = 7; i >= 0; i--) m_clk(b[i], rd);
    m_clk(1'b1, rd);
    ack = !rd;
  endtask

  task automatic m_read(input logic mack, output logic [7:0] b);
    logic rd;
    for (int i = 7; i >= 0; i--) begin
      m_clk(1'b1, rd);
      b[i] = rd;
    end
    m_clk(!mack, rd);
  endtask

  task automatic clr_irq();
    irq_clr = 1'b1;
    wait_cyc(1);
    irq_clr = 1'b0;
    wait_cyc(1);
  endtask

  initial begin
    wait_cyc(150000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic ack;
    logic [7:0] b, last_rx;
    wait_cyc(10);
    rst_n = 1'b1;
    wait_cyc(5);
    // R1 reset state
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rx_data", rx_data, 0);

    // R2/R3/R4: sweep all addresses, write direction
    for (int a = 0; a < 128; a++) begin
      logic exp_hit;
      exp_hit = (a == OWN_A) || (a == 0);
      m_start();
      m_write({a[6:0], 1'b0}, ack);
      if (exp_hit) begin
        chk("R2 sweep ack", ack, 1);
        chk("R2 sweep irq", irq, 1);
        chk("R3 sweep is_gc", is_gc, (a == 0));
        chk("R5 sweep hold", scl_oe, 1);
        clr_irq();
      end else begin
        chk("R4 sweep ack", ack, 0);
        chk("R4 sweep irq", irq, 0);
        chk("R4 sweep released", {scl_oe, sda_oe}, 0);
      end
      m_stop();
    end

    // R3: general call ignored when disabled
    gc_en = 1'b0;
    m_start();
    m_write(8'h00, ack);
    chk("R3 gc off ack", ack, 0);
    chk("R3 gc off irq", irq, 0);
    m_stop();
    gc_en = 1'b1;

    // R2: own address refused when ack_en is 0
    ack_en = 1'b0;
    m_start();
    m_write({OWN_A, 1'b0}, ack);
    chk("R2 ack_en off ack", ack, 0);
    chk("R2 ack_en off irq", irq, 0);
    m_stop();
    ack_en = 1'b1;

    // R2: reprogrammed address
    own_addr = OWN_B;
    m_start();
    m_write({OWN_A, 1'b0}, ack);
    chk("R2 old addr ack", ack, 0);
    m_start();
    m_write({OWN_B, 1'b0}, ack);
    chk("R2 new addr ack", ack, 1);
    chk("R2 new addr is_gc", is_gc, 0);
    clr_irq();
    m_stop();
    own_addr = OWN_A;

    // R5/R6: receiver data series
    m_start();
    m_write({OWN_A, 1'b0}, ack);
    chk("R6 rx addr ack", ack, 1);
    chk("R6 rx is_tx", is_tx, 0);
    clr_irq();
    last_rx = 8'h00;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] d;
      d = 8'((i * 37 + 11) & 255);
      m_write(d, ack);
      chk("R6 rx ack", ack, 1);
      chk("R6 rx irq", irq, 1);
      chk("R6 rx data", rx_data, d);
      chk("R5 rx hold", scl_oe, 1);
      if (i == 3) begin
        wait_cyc(40);
        chk("R5 long hold", {scl_oe, scl_line}, 2'b10);
      end
      clr_irq();
      chk("R5 irq cleared", irq, 0);
      chk("R5 scl released", scl_oe, 0);
      last_rx = d;
    end
    // R7: data refused
    ack_en = 1'b0;
    m_write(8'h5A, ack);
    chk("R7 nack", ack, 0);
    chk("R7 no irq", irq, 0);
    chk("R7 rx kept", rx_data, last_rx);
    chk("R7 no hold", scl_oe, 0);
    m_write(8'h33, ack);
    chk("R7 silent ack", ack, 0);
    chk("R7 silent irq", irq, 0);
    ack_en = 1'b1;
    m_stop();

    // R8/R9: transmitter series
    m_start();
    m_write({OWN_A, 1'b1}, ack);
    chk("R8 tx addr ack", ack, 1);
    chk("R8 is_tx", is_tx, 1);
    chk("R8 tx irq", irq, 1);
    for (int i = 0; i < 6; i++) begin
      logic [7:0] v;
      v = 8'((i * 73 + 15) & 255);
      tx_data = v;
      clr_irq();
      tx_data = ~v;
      m_read(i != 5, b);
      chk("R8 tx byte", b, v);
      if (i != 5) begin
        chk("R8 tx irq", irq, 1);
        chk("R5 tx hold", scl_oe, 1);
      end
    end
    chk("R9 no irq", irq, 0);
    chk("R9 released", {scl_oe, sda_oe}, 0);
    m_read(1'b0, b);
    chk("R9 silent", b, 8'hFF);
    m_stop();

    // R10: repeated START mid-byte
    m_start();
    for (int i = 0; i < 4; i++) begin
      logic rd;
      m_clk(1'b1, rd);
    end
    m_start();
    m_write({OWN_A, 1'b0}, ack);
    chk("R10 mid-byte restart ack", ack, 1);
    chk("R10 mid-byte irq", irq, 1);
    clr_irq();
    m_stop();
    // R10: repeated START after a miss
    m_start();
    m_write(8'hFE, ack);
    chk("R10 miss ack", ack, 0);
    m_start();
    m_write({OWN_A, 1'b1}, ack);
    chk("R10 after miss ack", ack, 1);
    chk("R10 after miss is_tx", is_tx, 1);
    tx_data = 8'hC3;
    clr_irq();
    m_read(1'b0, b);
    chk("R10 after miss byte", b, 8'hC3);
    m_stop();

    // R11: no START after STOP
    m_write({OWN_A, 1'b0}, ack);
    chk("R11 no start ack", ack, 0);
    chk("R11 no start irq", irq, 0);
    m_stop();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule